// File: doc/BRIEF.md
# Dual-Clock FIFO with Half-Full Flag

A 16-bit first-in first-out buffer whose write and read ports run on unrelated clocks. The write side stores one word on each write-clock edge while its active-low write enable is low and the buffer is not full. The read side moves the oldest word into a registered output on each read-clock edge while its active-low read enable is low and the buffer is not empty. When reads are idle the output register holds its value. Nothing reaches the output until it is requested, and this includes the first word written into an empty buffer.

Three active-low status flags are produced. Full is registered in the write domain and empty in the read domain. Half-full is raised by the write that takes the word count above half the depth, and it is cleared on a request from the read side once the count has fallen back to half or less. Pointers cross between the domains in Gray code through two-flop synchronisers. A release of full or empty may therefore arrive a cycle or two later than the edge that caused it. An active-low output enable drives the data bus to high impedance. The depth is a power-of-two parameter, 256 words by default.

Top module: `dcfifo_hf`

## Requirements
- R1: A word is stored on a rising write-clock edge when wen_ni is low and full_no is high. Words leave in the order in which they were stored.
- R2: On a rising read-clock edge with ren_ni low and empty_no high, the next word is loaded into the output register. With ren_ni high, q_o keeps its previous value.
- R3: A write attempted while full_no is low is dropped, and a read attempted while empty_no is low leaves q_o and the read pointer unchanged.
- R4: A word written into an empty buffer does not appear on q_o until a read request is made.
- R5: full_no goes low on the write that stores word DEPTH with no reads in between. It returns high within a few write-clock cycles of the first read after that.
- R6: empty_no goes low when the last stored word is read. It goes high within a few read-clock cycles of a write into an empty buffer.
- R7: hf_no goes low on write DEPTH/2+1 with no reads in between. It stays low while the count is above DEPTH/2, and it returns high within a few write-clock cycles once reads bring the count to DEPTH/2 or below.
- R8: While rst_ni is low, both pointers return to location zero, q_o reads all zeros, empty_no is low, full_no is high and hf_no is high. After release, the first word written is the first word read.
- R9: With oe_ni high, q_o is high impedance. With oe_ni low, q_o drives the output register.
- R10: With the two clocks at unrelated frequencies and enables toggling randomly, every word is read exactly once and in order. The Gray pointers change by at most one bit per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk_i | input | 1 | Write clock |
| rst_ni | input | 1 | Asynchronous reset, active low, common to both domains |
| wen_ni | input | 1 | Write enable, active low |
| din_i | input | 16 | Write data |
| rclk_i | input | 1 | Read clock |
| ren_ni | input | 1 | Read enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| q_o | output | 16 | Registered read data, high impedance when oe_ni is high |
| empty_no | output | 1 | Empty flag, active low, read-clock domain |
| full_no | output | 1 | Full flag, active low, write-clock domain |
| hf_no | output | 1 | Half-full flag, active low |

## Verification
The bench builds the block with DEPTH set to 16. With that setting, full is reached in 16 writes and the half-full threshold at write 9. Directed fills and drains can then cross both thresholds in each direction within a few hundred cycles, and the random phase with a 10 ns write clock and a 14 ns read clock reaches full and empty many times. At this depth the Gray pointers also wrap often, so the wrap of the pointer MSB and the comparison with inverted top bits are exercised repeatedly under asynchronous stimulus.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;
  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray2bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/dcfifo_sync.sv
module dcfifo_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/dcfifo_wr.sv
module dcfifo_wr
  import dcfifo_pkg::*;
#(
  parameter int unsigned AW = 8,
  localparam int unsigned PW = AW + 1
) (
  input  logic          wclk_i,
  input  logic          rst_ni,
  input  logic          wen_ni,
  input  logic [PW-1:0] rgray_sync_i,
  input  logic          hf_clr_sync_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [PW-1:0] wgray_o,
  output logic          full_o,
  output logic          hf_o
);
  localparam logic [PW-1:0] HALF = {2'b01, {(AW-1){1'b0}}};

  logic [PW-1:0] wbin_q, wbin_nx, wgray_nx, rbin_s, cnt_nx, rgray_inv;
  logic          full_nx;

  assign we_o      = ~wen_ni & ~full_o;
  assign wbin_nx   = wbin_q + PW'(we_o);
  assign wgray_nx  = PW'(bin2gray(32'(wbin_nx)));
  assign rbin_s    = PW'(gray2bin(32'(rgray_sync_i)));
  assign cnt_nx    = wbin_nx - rbin_s;
  assign rgray_inv = {~rgray_sync_i[PW-1:PW-2], rgray_sync_i[PW-3:0]};
  assign full_nx   = (wgray_nx == rgray_inv);
  assign waddr_o   = wbin_q[AW-1:0];

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_o <= '0;
      full_o  <= 1'b0;
    end else begin
      wbin_q  <= wbin_nx;
      wgray_o <= wgray_nx;
      full_o  <= full_nx;
    end
  end

  // set on the write that exceeds half; clear only on read-side request
  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni)                              hf_o <= 1'b0;
    else if (!hf_clr_sync_i && cnt_nx > HALF) hf_o <= 1'b1;
    else if (hf_clr_sync_i && cnt_nx <= HALF) hf_o <= 1'b0;
  end

  p_no_overflow_r3: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    full_o |=> wbin_q == $past(wbin_q));
  p_wgray_step_r10: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    $countones(wgray_o ^ $past(wgray_o)) <= 1);
  p_full_has_hf_r7: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    full_o |-> hf_o);
endmodule

// File: rtl/dcfifo_rd.sv
module dcfifo_rd
  import dcfifo_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 16,
  localparam int unsigned PW = AW + 1
) (
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          ren_ni,
  input  logic [PW-1:0] wgray_sync_i,
  input  logic          hf_sync_i,
  input  logic [DW-1:0] rdata_i,
  output logic [AW-1:0] raddr_o,
  output logic [PW-1:0] rgray_o,
  output logic          empty_o,
  output logic [DW-1:0] q_o,
  output logic          hf_clr_o
);
  localparam logic [PW-1:0] HALF = {2'b01, {(AW-1){1'b0}}};

  logic [PW-1:0] rbin_q, rbin_nx, rgray_nx, wbin_s, cnt_nx;
  logic          re;

  assign re       = ~ren_ni & ~empty_o;
  assign rbin_nx  = rbin_q + PW'(re);
  assign rgray_nx = PW'(bin2gray(32'(rbin_nx)));
  assign wbin_s   = PW'(gray2bin(32'(wgray_sync_i)));
  assign cnt_nx   = wbin_s - rbin_nx;
  assign raddr_o  = rbin_q[AW-1:0];

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q   <= '0;
      rgray_o  <= '0;
      empty_o  <= 1'b1;
      q_o      <= '0;
      hf_clr_o <= 1'b0;
    end else begin
      rbin_q   <= rbin_nx;
      rgray_o  <= rgray_nx;
      empty_o  <= (rgray_nx == wgray_sync_i);
      if (re) q_o <= rdata_i;
      hf_clr_o <= hf_sync_i && (cnt_nx <= HALF);
    end
  end

  p_no_underflow_r3: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    empty_o |=> rbin_q == $past(rbin_q));
  p_hold_idle_r2: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    ren_ni |=> $stable(q_o));
  p_rgray_step_r10: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    $countones(rgray_o ^ $past(rgray_o)) <= 1);
endmodule

// File: rtl/dcfifo_hf.sv
module dcfifo_hf #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned DW    = 16,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned PW   = AW + 1
) (
  input  logic          wclk_i,
  input  logic          rst_ni,
  input  logic          wen_ni,
  input  logic [DW-1:0] din_i,
  input  logic          rclk_i,
  input  logic          ren_ni,
  input  logic          oe_ni,
  output logic [DW-1:0] q_o,
  output logic          empty_no,
  output logic          full_no,
  output logic          hf_no
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
  logic          we, full, empty, hf, hf_s, hf_clr, hf_clr_s;
  logic [DW-1:0] q_reg;

  dcfifo_wr #(.AW(AW)) u_wr (
    .wclk_i, .rst_ni, .wen_ni,
    .rgray_sync_i (rgray_s),
    .hf_clr_sync_i(hf_clr_s),
    .we_o         (we),
    .waddr_o      (waddr),
    .wgray_o      (wgray),
    .full_o       (full),
    .hf_o         (hf)
  );

  dcfifo_rd #(.AW(AW), .DW(DW)) u_rd (
    .rclk_i, .rst_ni, .ren_ni,
    .wgray_sync_i(wgray_s),
    .hf_sync_i   (hf_s),
    .rdata_i     (mem[raddr]),
    .raddr_o     (raddr),
    .rgray_o     (rgray),
    .empty_o     (empty),
    .q_o         (q_reg),
    .hf_clr_o    (hf_clr)
  );

  dcfifo_sync #(.W(PW)) u_sync_r2w (.clk_i(wclk_i), .rst_ni, .d_i(rgray),  .q_o(rgray_s));
  dcfifo_sync #(.W(PW)) u_sync_w2r (.clk_i(rclk_i), .rst_ni, .d_i(wgray),  .q_o(wgray_s));
  dcfifo_sync #(.W(1))  u_sync_hf  (.clk_i(rclk_i), .rst_ni, .d_i(hf),     .q_o(hf_s));
  dcfifo_sync #(.W(1))  u_sync_clr (.clk_i(wclk_i), .rst_ni, .d_i(hf_clr), .q_o(hf_clr_s));

  always_ff @(posedge wclk_i) begin
    if (we) mem[waddr] <= din_i;
  end

  assign q_o      = oe_ni ? {DW{1'bz}} : q_reg;
  assign empty_no = ~empty;
  assign full_no  = ~full;
  assign hf_no    = ~hf;

  p_clr_needs_hf_r7: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    hf_clr |-> $past(hf_s));
endmodule

// File: tb/dcfifo_hf_tb_top.sv
`timescale 1ns/1ps
module dcfifo_hf_tb_top;
  localparam int D = 16;

  logic        wclk = 0, rclk = 0, rst_ni = 0;
  logic        wen_ni = 1, ren_ni = 1, oe_ni = 0;
  logic [15:0] din = '0;
  wire  [15:0] q_o;
  wire         empty_no, full_no, hf_no;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [15:0] model [$];
  logic [15:0] last_q = '0;

  always #5 wclk = ~wclk;
  always #7 rclk = ~rclk;

  dcfifo_hf #(.DEPTH(D), .DW(16)) dut_i (
    .wclk_i(wclk), .rst_ni, .wen_ni, .din_i(din),
    .rclk_i(rclk), .ren_ni, .oe_ni, .q_o,
    .empty_no, .full_no, .hf_no
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_word(input logic [15:0] d);
    @(negedge wclk);
    wen_ni = 0; din = d;
    if (full_no) model.push_back(d);
    @(negedge wclk);
    wen_ni = 1;
  endtask

  task automatic rd_word(input string req);
    logic [15:0] e;
    bit          v;
    @(negedge rclk);
    ren_ni = 0;
    v = empty_no;
    if (v) begin e = model.pop_front(); last_q = e; end
    @(negedge rclk);
    ren_ni = 1;
    chk(req, q_o, last_q);
  endtask

  task automatic wait_w(input int n);
    repeat (n) @(negedge wclk);
  endtask

  task automatic wait_r(input int n);
    repeat (n) @(negedge rclk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #1ms;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    wait_w(3);
    // reset state, R8
    chk("R8 q_o", q_o, 16'h0);
    chk("R8 empty_no", empty_no, 1'b0);
    chk("R8 full_no", full_no, 1'b1);
    chk("R8 hf_no", hf_no, 1'b1);
    @(negedge wclk); rst_ni = 1;
    wait_w(2);

    // read on empty ignored, R3
    rd_word("R3 read while empty");
    chk("R3 q_o after empty read", q_o, 16'h0);

    // no fall-through, R4 / R6
    wr_word(16'hA5A5);
    wait_r(8);
    chk("R4 no fall-through", q_o, 16'h0);
    chk("R6 empty_no after write", empty_no, 1'b1);
    rd_word("R2 first word on request");
    wait_r(4);
    chk("R6 empty_no after last read", empty_no, 1'b0);

    // half-full and full, R7 / R5 / R1
    for (int i = 0; i < D/2; i++) wr_word(16'h1000 + 16'(i));
    wait_w(4);
    chk("R7 hf_no at half", hf_no, 1'b1);
    wr_word(16'h1000 + 16'(D/2));
    wait_w(2);
    chk("R7 hf_no above half", hf_no, 1'b0);
    for (int i = D/2 + 1; i < D - 1; i++) wr_word(16'h1000 + 16'(i));
    wait_w(2);
    chk("R5 full_no before last", full_no, 1'b1);
    wr_word(16'h1000 + 16'(D - 1));
    chk("R5 full_no at depth", full_no, 1'b0);
    wr_word(16'hDEAD);
    chk("R3 full_no after dropped write", full_no, 1'b0);
    chk("R3 model size", model.size(), D);

    // output enable, R9
    @(negedge rclk);
    oe_ni = 1; #1;
    checks++;
    if (!(q_o === 16'hzzzz || q_o === 16'h0)) begin
      errors++;
      $display("FAIL R9 hi-z: actual=%h expected=zzzz", q_o);
    end
    oe_ni = 0; #1;
    chk("R9 drive", q_o, 16'hA5A5);

    // drain, R5 / R7 / R1
    rd_word("R1 order");
    wait_w(6);
    chk("R5 full_no after read", full_no, 1'b1);
    for (int i = 0; i < D/2 - 2; i++) rd_word("R1 order");
    wait_w(12);
    chk("R7 hf_no still above half", hf_no, 1'b0);
    rd_word("R1 order");
    wait_w(12);
    chk("R7 hf_no back at half", hf_no, 1'b1);
    while (model.size() > 0) rd_word("R1 order");
    wait_r(4);
    chk("R6 empty_no drained", empty_no, 1'b0);
    rd_word("R3 read while empty holds q");

    // random asynchronous traffic, R10
    fork
      begin : wr_proc
        for (int c = 0; c < 4000; c++) begin
          int pct;
          pct = ((c / 500) % 2 == 0) ? 75 : 30;
          @(negedge wclk);
          wen_ni = ($urandom % 100) >= pct;
          din = 16'($urandom);
          if (!wen_ni && full_no) model.push_back(din);
        end
        @(negedge wclk); wen_ni = 1;
      end
      begin : rd_proc
        bit pend = 0;
        for (int c = 0; c < 2850; c++) begin
          int pct;
          pct = ((c / 360) % 2 == 0) ? 35 : 80;
          @(negedge rclk);
          if (pend) chk("R10 random order", q_o, last_q);
          else      chk("R2 hold when idle", q_o, last_q);
          ren_ni = ($urandom % 100) >= pct;
          pend = 0;
          if (!ren_ni && empty_no) begin
            last_q = model.pop_front();
            pend = 1;
          end
        end
        @(negedge rclk);
        ren_ni = 1;
        if (pend) chk("R10 random order", q_o, last_q);
      end
    join
    wait_r(8);
    while (model.size() > 0) rd_word("R10 drain order");
    wait_r(4);
    chk("R10 empty after drain", empty_no, 1'b0);

    // reset mid-operation, R8
    wr_word(16'h0111); wr_word(16'h0222); wr_word(16'h0333);
    wait_r(6);
    rd_word("R1 before reset");
    @(negedge wclk);
    rst_ni = 0; #2;
    model.delete();
    last_q = '0;
    chk("R8 q_o in reset", q_o, 16'h0);
    chk("R8 empty_no in reset", empty_no, 1'b0);
    chk("R8 full_no in reset", full_no, 1'b1);
    chk("R8 hf_no in reset", hf_no, 1'b1);
    wait_w(2);
    @(negedge wclk); rst_ni = 1;
    wait_w(2);
    wr_word(16'h0BEE);
    wait_r(6);
    rd_word("R8 first word after reset");
    wait_r(4);
    chk("R8 empty after single word", empty_no, 1'b0);

    finish_run();
  end
endmodule